// File: doc/BRIEF.md
# Two-Delta Stride Value Predictor

This block predicts the next result of an instruction from the results it produced before. A small table, indexed by low bits of the program counter and tagged with the remaining bits, keeps one entry per static instruction. Each entry holds three fields: the last result seen, a candidate stride, and a confirmed stride. A prediction is the last result plus the confirmed stride.

The candidate stride always takes the newest difference between consecutive results. The confirmed stride changes only when two updates in a row produce the same difference. Because of this, a single irregular result does not disturb a stride that is already established.

The lookup side takes a program counter and answers one cycle later with a value and a valid flag. The training side takes a program counter and the actual result, and adjusts that entry in the same clock edge.

Top module: `stride_value_predictor`

## Requirements
- R1: After reset every entry is empty. `pred_valid` is 0 until some entry has been trained.
- R2: `pred_valid` and `pred_value` answer the lookup sampled at the previous clock edge. `pred_valid` is 0 in any cycle that follows a clock edge at which `pred_en` was 0.
- R3: The entry index is `pc[IDX_W-1:0]` and the tag is `pc[PC_W-1:IDX_W]`. A lookup whose tag differs from the stored tag returns `pred_valid` 0.
- R4: An update that misses allocates the entry. A miss is an empty entry or a tag mismatch. Allocation stores the result and sets both strides to 0. The entry gives no valid prediction until it receives one further update that hits.
- R5: An update that hits does three things: it stores the new difference (result minus last result) as the candidate stride, stores the result as the last result, and makes the entry predictable. A prediction returns the last result plus the confirmed stride.
- R6: The confirmed stride takes the new difference only when that difference equals the candidate stride left by the previous update.
- R7: A repeated constant result predicts that same constant once the entry has seen two updates.
- R8: All result and stride arithmetic wraps modulo 2^VAL_W. Negative strides therefore work.
- R9: When a lookup and an update address the same entry in one cycle, the lookup answers from the contents as they were before the update.
- R10: A single irregular difference does not change a confirmed stride. For example, results 0, 4, 8, 100 predict 104, and a following 104 predicts 108.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_en | input | 1 | Lookup request |
| pred_pc | input | PC_W | Program counter to look up |
| upd_en | input | 1 | Training request |
| upd_pc | input | PC_W | Program counter of the trained instruction |
| upd_value | input | VAL_W | Actual result of that instruction |
| pred_valid | output | 1 | Prediction is usable |
| pred_value | output | VAL_W | Predicted result |

## Verification
The predictor is driven with several kinds of result sequence. A steady positive stride shows the one-update delay before the confirmed stride moves. A constant sequence shows the zero-stride case. A descending sequence and one that crosses the top of the value range show that the arithmetic wraps. A sequence with a single outlier separates two-delta hysteresis from plain last-difference prediction. Aliasing program counters that share an index exercise tag misses and reallocation. Lookups that coincide with updates to the same entry show that reads return the pre-update contents. A long mixed run, with per-stream strides that change now and then, is compared against an independent table model.

// File: rtl/stride_value_predictor.sv
module stride_value_predictor #(
  parameter int PC_W  = 32,
  parameter int VAL_W = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pred_en,
  input  logic [PC_W-1:0]  pred_pc,
  input  logic             upd_en,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic [VAL_W-1:0] upd_value,
  output logic             pred_valid,
  output logic [VAL_W-1:0] pred_value
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W;

  logic [ENTRIES-1:0] live_q, armed_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [VAL_W-1:0]   last_q [ENTRIES];
  logic [VAL_W-1:0]   cand_q [ENTRIES];
  logic [VAL_W-1:0]   conf_q [ENTRIES];

  wire [IDX_W-1:0] p_idx = pred_pc[IDX_W-1:0];
  wire [TAG_W-1:0] p_tag = pred_pc[PC_W-1:IDX_W];
  wire [IDX_W-1:0] u_idx = upd_pc[IDX_W-1:0];
  wire [TAG_W-1:0] u_tag = upd_pc[PC_W-1:IDX_W];

  wire             p_hit  = live_q[p_idx] && armed_q[p_idx] && (tag_q[p_idx] == p_tag);
  wire             u_hit  = live_q[u_idx] && (tag_q[u_idx] == u_tag);
  wire [VAL_W-1:0] u_diff = upd_value - last_q[u_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_valid <= 1'b0;
      pred_value <= '0;
    end else begin
      pred_valid <= pred_en && p_hit;
      if (pred_en) pred_value <= last_q[p_idx] + conf_q[p_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= '0;
      armed_q <= '0;
    end else if (upd_en) begin
      live_q[u_idx]  <= 1'b1;
      armed_q[u_idx] <= u_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en && rst_n) begin
      tag_q[u_idx]  <= u_tag;
      last_q[u_idx] <= upd_value;
      if (u_hit) begin
        cand_q[u_idx] <= u_diff;
        if (u_diff == cand_q[u_idx]) conf_q[u_idx] <= u_diff;
      end else begin
        cand_q[u_idx] <= '0;
        conf_q[u_idx] <= '0;
      end
    end
  end
endmodule

// File: rtl/stride_value_predictor_checker.sv
module stride_value_predictor_checker #(
  parameter int PC_W  = 32,
  parameter int VAL_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pred_en,
  input logic [PC_W-1:0]  pred_pc,
  input logic             upd_en,
  input logic             pred_valid,
  input logic [VAL_W-1:0] pred_value
);
  logic [1:0] upd_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_seen <= '0;
    else if (upd_en && upd_seen != 2'd2) upd_seen <= upd_seen + 2'd1;
  end

  assert_known_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(pred_valid));

  assert_valid_needs_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> $past(pred_en));

  assert_fresh_entry_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> (upd_seen == 2'd2));

  assert_read_before_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_en && $past(pred_en) && pred_pc == $past(pred_pc) && !$past(upd_en))
    |=> (pred_valid == $past(pred_valid)) && (!pred_valid || pred_value == $past(pred_value)));
endmodule

bind stride_value_predictor stride_value_predictor_checker #(.PC_W(PC_W), .VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_en(pred_en), .pred_pc(pred_pc),
  .upd_en(upd_en), .pred_valid(pred_valid), .pred_value(pred_value)
);

// File: tb/tb_stride_value_predictor.sv
`timescale 1ns/1ps
module tb_stride_value_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pred_en = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        upd_en = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [31:0] upd_value = '0;
  logic        pred_valid;
  logic [31:0] pred_value;

  stride_value_predictor #(.PC_W(32), .VAL_W(32), .IDX_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .pred_en(pred_en), .pred_pc(pred_pc),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_value(upd_value),
    .pred_valid(pred_valid), .pred_value(pred_value)
  );

  always #2.5 clk = ~clk;

  typedef struct { bit v; logic [31:0] val; string rq; } exp_t;
  exp_t q[$];
  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  bit issued = 1'b0;

  bit          m_live [16];
  bit          m_rdy  [16];
  logic [27:0] m_tag  [16];
  logic [31:0] m_last [16], m_s1 [16], m_s2 [16];

  task automatic step(input bit pe, input logic [31:0] ppc, input bit ue,
                      input logic [31:0] upc, input logic [31:0] uval, input string rq);
    exp_t e;
    int pi, ui;
    logic [31:0] d;
    @(negedge clk);
    pred_en = pe; pred_pc = ppc; upd_en = ue; upd_pc = upc; upd_value = uval;
    pi = int'(ppc[3:0]);
    ui = int'(upc[3:0]);
    if (pe) begin
      e.v = m_live[pi] && m_rdy[pi] && (m_tag[pi] == ppc[31:4]);
      e.val = m_last[pi] + m_s2[pi];
      e.rq = rq;
      q.push_back(e);
    end
    if (ue) begin
      if (m_live[ui] && m_tag[ui] == upc[31:4]) begin
        d = uval - m_last[ui];
        if (d == m_s1[ui]) m_s2[ui] = d;
        m_s1[ui] = d;
        m_rdy[ui] = 1'b1;
      end else begin
        m_live[ui] = 1'b1; m_tag[ui] = upc[31:4];
        m_s1[ui] = '0; m_s2[ui] = '0; m_rdy[ui] = 1'b0;
      end
      m_last[ui] = uval;
    end
  endtask

  task automatic upd(input logic [31:0] pc, input logic [31:0] v, input string rq);
    step(1'b0, '0, 1'b1, pc, v, rq);
  endtask

  task automatic look(input logic [31:0] pc, input string rq);
    step(1'b1, pc, 1'b0, '0, '0, rq);
  endtask

  always @(posedge clk) issued <= rst_n && pred_en;

  always @(negedge clk) begin
    exp_t e;
    if (rst_n && !done) begin
      if (issued) begin
        compared++;
        if (q.size() == 0) begin
          mismatched++;
          $display("FAIL R2: result without pending lookup (valid=%0b)", pred_valid);
        end else begin
          e = q.pop_front();
          if (pred_valid !== e.v || (e.v && pred_value !== e.val)) begin
            mismatched++;
            $display("FAIL %s: got valid=%0b value=%h, expected valid=%0b value=%h",
                     e.rq, pred_valid, pred_value, e.v, e.val);
          end
        end
      end else if (pred_valid !== 1'b0) begin
        compared++; mismatched++;
        $display("FAIL R2: valid=%0b without lookup, expected 0", pred_valid);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] sv [4];
    logic [31:0] st [4];
    logic [31:0] spc [4];
    for (int i = 0; i < 16; i++) begin
      m_live[i] = 0; m_rdy[i] = 0; m_tag[i] = '0; m_last[i] = '0; m_s1[i] = '0; m_s2[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    compared++;
    if (pred_valid !== 1'b0 || pred_value !== 32'h0) begin
      mismatched++;
      $display("FAIL R1: reset outputs valid=%0b value=%h, expected 0/0", pred_valid, pred_value);
    end
    rst_n = 1'b1;

    look(32'h0000_0005, "R1");
    // R4 allocation then stride 3
    upd(32'h10, 32'd10, "R4");
    look(32'h10, "R4");
    upd(32'h10, 32'd13, "R5");
    look(32'h10, "R5");
    upd(32'h10, 32'd16, "R6");
    look(32'h10, "R6");
    upd(32'h10, 32'd19, "R6");
    look(32'h10, "R6");
    // R7 constant
    upd(32'h21, 32'd7, "R7");
    upd(32'h21, 32'd7, "R7");
    look(32'h21, "R7");
    upd(32'h21, 32'd7, "R7");
    look(32'h21, "R7");
    // R10 outlier
    upd(32'h32, 32'd0, "R10");
    upd(32'h32, 32'd4, "R10");
    upd(32'h32, 32'd8, "R10");
    upd(32'h32, 32'd100, "R10");
    look(32'h32, "R10");
    upd(32'h32, 32'd104, "R10");
    look(32'h32, "R10");
    // R8 wrap upward and negative stride
    upd(32'h43, 32'hFFFF_FFFE, "R8");
    upd(32'h43, 32'hFFFF_FFFF, "R8");
    upd(32'h43, 32'h0000_0000, "R8");
    look(32'h43, "R8");
    upd(32'h54, 32'd5, "R8");
    upd(32'h54, 32'd3, "R8");
    upd(32'h54, 32'd1, "R8");
    look(32'h54, "R8");
    // R3 aliasing tag miss, R4 reallocation
    look(32'h110, "R3");
    upd(32'h110, 32'd50, "R4");
    look(32'h10, "R3");
    look(32'h110, "R4");
    upd(32'h110, 32'd60, "R5");
    look(32'h110, "R5");
    // R9 same-cycle lookup and update
    step(1'b1, 32'h21, 1'b1, 32'h21, 32'd9, "R9");
    look(32'h21, "R9");
    step(1'b1, 32'h21, 1'b1, 32'h21, 32'd11, "R9");
    step(1'b1, 32'h21, 1'b1, 32'h21, 32'd13, "R9");
    look(32'h21, "R9");

    // mixed run, R6 against model
    for (int k = 0; k < 4; k++) begin
      spc[k] = 32'h1005 + 32'h1001 * k;
      sv[k] = $urandom;
      st[k] = $urandom % 16;
    end
    for (int n = 0; n < 600; n++) begin
      int k, j;
      k = int'($urandom % 4);
      j = int'($urandom % 4);
      if ($urandom % 10 == 0) st[k] = $urandom;
      sv[k] = sv[k] + st[k];
      step($urandom % 4 != 0, spc[j], $urandom % 5 != 0, spc[k], sv[k], "R6");
    end
    step(1'b0, '0, 1'b0, '0, '0, "R2");
    @(negedge clk);
    @(negedge clk);
    compared++;
    if (q.size() != 0) begin
      mismatched++;
      $display("FAIL R2: %0d lookups unanswered, expected 0", q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule